// File: doc/BRIEF.md
# Sequential Radix-2 Booth Multiplier

This block multiplies two 8-bit two's-complement numbers and returns their 16-bit signed product, one multiplier bit per clock cycle. It recodes the multiplier on the fly: each step inspects the two lowest bits of a combined working register and either adds the multiplicand, adds its negation, or adds nothing. The register then shifts right arithmetically. Negative operands need no sign-magnitude conversion before or after the loop.

A request on `start_i` while the block is idle captures both operands. It also captures a precomputed negated copy of the multiplicand. Eight step cycles follow, and `done_o` then pulses for one cycle while the result appears on `prod_o`. The result stays there until the next operation finishes. A request made while a computation is in flight is dropped. Holding the request high chains operations back to back, with one result every nine cycles.

Top module: `booth_seq_mul`

## Requirements
- R1: While `rst_n` is low, and after its release until the first operation completes, `done_o` is 0 and `prod_o` is 0.
- R2: Both operands are captured on the rising edge at which `start_i` is accepted. Later changes on `mcand_i` and `mplier_i` do not affect that operation's result.
- R3: `done_o` is 1 after exactly the eighth rising edge following the accepting edge, is 0 before it, and returns to 0 after the next edge.
- R4: When `done_o` is 1, `prod_o` equals the low 16 bits of the signed product `mcand × mplier`, both read as 8-bit two's complement, for every operand pair.
- R5: An operand of -128 (8'h80) gives the exact product. In particular, (-128)×(-128) gives +16384 (16'h4000).
- R6: `start_i` seen at any edge while an operation is running is ignored. This includes the edge of the final step: the running operation's timing and result are unchanged and no new operation starts.
- R7: `prod_o` changes only at the edge that raises `done_o`. At all other edges it holds its value.
- R8: The two lowest working bits are read as a pair, with the lower bit being the bit shifted out last. A pair of 01 adds the multiplicand to the upper part, and a pair of 10 adds its negation. A pair of 00 or 11 adds nothing. Every step then shifts right by one with the top bit replicated.
- R9: A `start_i` held high is accepted again on the edge that ends the `done_o` pulse, so consecutive results arrive nine cycles apart.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request to begin a multiplication when idle |
| mcand_i | input | 8 | Multiplicand, two's complement |
| mplier_i | input | 8 | Multiplier, two's complement |
| done_o | output | 1 | One-cycle pulse when the result is ready |
| prod_o | output | 16 | Signed product, held until the next completion |

## Verification
The sweep pairs every multiplicand value with a set of edge multipliers, and then swaps the roles. The multiplier set covers all-zero, all-one, alternating and single-bit patterns. A broken recode table or a logical instead of arithmetic shift would corrupt exactly those products. The -128 cases target an accumulator that is one bit too narrow, which would return -16384 for (-128)×(-128). Directed runs change the operands after capture and raise the request mid-operation and during the final step. A design that resampled its inputs, restarted, or shifted its done pulse would show a wrong product or a misplaced pulse. A chained run with the request held high exposes a lost or duplicated hand-off between operations.

// File: rtl/booth_mul_pkg.sv
package booth_mul_pkg;

   // action selected for one step from the two lowest working bits
   typedef enum logic [1:0] {
      BOP_NONE = 2'd0,
      BOP_ADD  = 2'd1,
      BOP_SUB  = 2'd2
   } booth_op_e;

   typedef enum logic {
      SEQ_IDLE = 1'b0,
      SEQ_RUN  = 1'b1
   } seq_state_e;

   // radix-2 recoding: {current bit, previously shifted bit}
   function automatic booth_op_e booth_recode(input logic [1:0] pair);
      booth_op_e op;
      case (pair)
         2'b01:   op = BOP_ADD;
         2'b10:   op = BOP_SUB;
         default: op = BOP_NONE;
      endcase
      return op;
   endfunction

endpackage

// File: rtl/booth_seq_ctrl.sv
module booth_seq_ctrl
   import booth_mul_pkg::*;
#(
   parameter int STEPS = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic go_i,
   output logic load_o,
   output logic step_o,
   output logic last_o,
   output logic done_o
);

   localparam int CW = (STEPS > 1) ? $clog2(STEPS) : 1;
   localparam logic [CW-1:0] LAST_CNT = CW'(STEPS - 1);

   initial begin
      assert (STEPS >= 2) else $error("booth_seq_ctrl: STEPS must be at least 2");
   end

   seq_state_e state_q;
   logic [CW-1:0] cnt_q;
   logic done_q;

   assign load_o = (state_q == SEQ_IDLE) && go_i;
   assign step_o = (state_q == SEQ_RUN);
   assign last_o = step_o && (cnt_q == LAST_CNT);
   assign done_o = done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SEQ_IDLE;
         cnt_q   <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= last_o;
         case (state_q)
            SEQ_IDLE: begin
               if (go_i) begin
                  state_q <= SEQ_RUN;
                  cnt_q   <= '0;
               end
            end
            default: begin
               cnt_q <= cnt_q + CW'(1);
               if (last_o) state_q <= SEQ_IDLE;
            end
         endcase
      end
   end

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o); // R3
   AST_LAST_RAISES_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      last_o |=> done_o); // R3
   AST_BUSY_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (step_o && !last_o) |=> (step_o && !load_o)); // R6
   AST_LAST_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (last_o && go_i) |=> !step_o); // R6

endmodule

// File: rtl/booth_operand_regs.sv
module booth_operand_regs #(
   parameter int OPW         = 8,
   parameter bit PRECOMP_NEG = 1'b1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           load_i,
   input  logic [OPW-1:0] mcand_i,
   output logic [OPW:0]   pos_o,
   output logic [OPW:0]   neg_o
);

   localparam int AW = OPW + 1;

   logic [AW-1:0] pos_q;
   logic [AW-1:0] mcand_ext;

   // one extra bit so that the negation of the most negative value fits
   assign mcand_ext = {mcand_i[OPW-1], mcand_i};
   assign pos_o     = pos_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      pos_q <= '0;
      else if (load_i) pos_q <= mcand_ext;
   end

   generate
      if (PRECOMP_NEG) begin : g_neg_stored
         logic [AW-1:0] neg_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      neg_q <= '0;
            else if (load_i) neg_q <= ~mcand_ext + AW'(1);
         end
         assign neg_o = neg_q;
      end else begin : g_neg_live
         assign neg_o = AW'(0) - pos_q;
      end
   endgenerate

   AST_OPERAND_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !load_i |=> $stable(pos_q)); // R2

endmodule

// File: rtl/booth_recode.sv
module booth_recode
   import booth_mul_pkg::*;
#(
   parameter int AW = 9
) (
   input  logic [1:0]    pair_i,
   input  logic [AW-1:0] pos_i,
   input  logic [AW-1:0] neg_i,
   output logic [AW-1:0] addend_o
);

   booth_op_e op;

   assign op = booth_recode(pair_i);

   always_comb begin
      case (op)
         BOP_ADD: addend_o = pos_i;
         BOP_SUB: addend_o = neg_i;
         default: addend_o = '0;
      endcase
   end

endmodule

// File: rtl/booth_step_dp.sv
module booth_step_dp #(
   parameter int OPW = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic             step_i,
   input  logic             last_i,
   input  logic [OPW-1:0]   mplier_i,
   input  logic [OPW:0]     addend_i,
   output logic [1:0]       pair_o,
   output logic [2*OPW-1:0] prod_next_o
);

   localparam int AW = OPW + 1;   // upper (accumulating) part
   localparam int LW = OPW + 1;   // multiplier bits plus the appended zero
   localparam int SW = AW + 1;    // sum width before the shift

   logic [AW-1:0] acc_q, acc_d;
   logic [LW-1:0] low_q, low_d;
   logic [SW-1:0] sum;

   assign pair_o = low_q[1:0];
   assign sum    = {addend_i[AW-1], addend_i} + {acc_q[AW-1], acc_q};

   // arithmetic right shift of {sum, low}
   assign acc_d = sum[SW-1:1];
   assign low_d = {sum[0], low_q[LW-1:1]};

   assign prod_next_o = {acc_d[OPW-1:0], low_d[LW-1:1]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q <= '0;
         low_q <= '0;
      end else if (load_i) begin
         acc_q <= '0;
         low_q <= {mplier_i, 1'b0};
      end else if (step_i) begin
         acc_q <= acc_d;
         low_q <= low_d;
      end
   end

   AST_IDLE_PAIR_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && !load_i && (pair_o[1] == pair_o[0]))
         |=> (acc_q == {$past(acc_q[AW-1]), $past(acc_q[AW-1:1])})); // R8
   AST_ACC_FITS: assert property (@(posedge clk) disable iff (!rst_n)
      last_i |=> (acc_q[AW-1] == acc_q[AW-2])); // R5

endmodule

// File: rtl/booth_seq_mul.sv
module booth_seq_mul #(
   parameter int OPW         = 8,
   parameter bit PRECOMP_NEG = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [OPW-1:0]   mcand_i,
   input  logic [OPW-1:0]   mplier_i,
   output logic             done_o,
   output logic [2*OPW-1:0] prod_o
);

   localparam int AW = OPW + 1;
   localparam int PW = 2 * OPW;

   initial begin
      assert (OPW >= 2) else $error("booth_seq_mul: OPW must be at least 2");
   end

   logic          load, step, last;
   logic [AW-1:0] pos, neg, addend;
   logic [1:0]    pair;
   logic [PW-1:0] prod_next;
   logic [PW-1:0] prod_q;

   booth_seq_ctrl #(.STEPS(OPW)) u_ctrl (
      .clk    (clk),
      .rst_n  (rst_n),
      .go_i   (start_i),
      .load_o (load),
      .step_o (step),
      .last_o (last),
      .done_o (done_o)
   );

   booth_operand_regs #(.OPW(OPW), .PRECOMP_NEG(PRECOMP_NEG)) u_ops (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_i  (load),
      .mcand_i (mcand_i),
      .pos_o   (pos),
      .neg_o   (neg)
   );

   booth_recode #(.AW(AW)) u_rec (
      .pair_i   (pair),
      .pos_i    (pos),
      .neg_i    (neg),
      .addend_o (addend)
   );

   booth_step_dp #(.OPW(OPW)) u_dp (
      .clk         (clk),
      .rst_n       (rst_n),
      .load_i      (load),
      .step_i      (step),
      .last_i      (last),
      .mplier_i    (mplier_i),
      .addend_i    (addend),
      .pair_o      (pair),
      .prod_next_o (prod_next)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    prod_q <= '0;
      else if (last) prod_q <= prod_next;
   end

   assign prod_o = prod_q;

   AST_PROD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !last |=> $stable(prod_o)); // R7
   AST_PROD_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(prod_o) |-> done_o); // R7

endmodule

// File: tb/sim_booth_seq_mul.sv
`timescale 1ns/1ps
module sim_booth_seq_mul;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start_i = 1'b0;
   logic [7:0] mcand_i = '0;
   logic [7:0] mplier_i = '0;
   logic       done_o;
   logic [15:0] prod_o;

   int n_chk = 0;
   int n_bad = 0;
   int cyc = 0;
   bit ended = 0;
   logic [15:0] prev_exp = '0;

   always #2.5 clk = ~clk;

   booth_seq_mul u0 (
      .clk(clk), .rst_n(rst_n), .start_i(start_i),
      .mcand_i(mcand_i), .mplier_i(mplier_i),
      .done_o(done_o), .prod_o(prod_o)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic logic [15:0] expmul(input logic [7:0] a, input logic [7:0] b);
      int p;
      p = $signed(a) * $signed(b);
      return p[15:0];
   endfunction

   // one operation; poke raises start_i in the middle and at the last step
   task automatic run_op(input logic [7:0] a, input logic [7:0] b,
                         input bit poke, input string tag);
      logic [15:0] e;
      e = expmul(a, b);
      @(negedge clk);
      mcand_i = a; mplier_i = b; start_i = 1'b1;
      @(posedge clk);                      // accepting edge
      @(negedge clk);
      start_i = 1'b0; mcand_i = ~a; mplier_i = b ^ 8'h5A;   // R2: ignored
      for (int k = 1; k <= 7; k++) begin
         @(posedge clk);
         @(negedge clk);
         if (poke && (k == 3 || k == 7)) start_i = 1'b1;  // R6: during busy / last step
         else start_i = 1'b0;
      end
      chk(done_o == 1'b0, "R3 done early", int'(done_o), 0);
      chk(prod_o == prev_exp, "R7 hold", int'($signed(prod_o)), int'($signed(prev_exp)));
      @(posedge clk);                      // eighth step edge
      @(negedge clk);
      start_i = 1'b0;
      chk(done_o == 1'b1, "R3 done", int'(done_o), 1);
      chk(prod_o == e, tag, int'($signed(prod_o)), int'($signed(e)));
      prev_exp = e;
      @(posedge clk);
      @(negedge clk);
      chk(done_o == 1'b0, poke ? "R6 no restart" : "R3 pulse width", int'(done_o), 0);
   endtask

   logic [7:0] corners [18] = '{8'h00, 8'h01, 8'h02, 8'h7F, 8'h7E, 8'h80,
                                8'h81, 8'hFF, 8'hFE, 8'h55, 8'hAA, 8'h0F,
                                8'hF0, 8'h33, 8'hCC, 8'h40, 8'hC0, 8'h6D};

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 195000 && !ended) begin
         ended = 1;
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 195000);
         $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      // R1: reset state
      repeat (3) @(negedge clk);
      chk(done_o == 1'b0, "R1 done in reset", int'(done_o), 0);
      chk(prod_o == 16'h0, "R1 prod in reset", int'(prod_o), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(done_o == 1'b0, "R1 done after reset", int'(done_o), 0);
      chk(prod_o == 16'h0, "R1 prod after reset", int'(prod_o), 0);

      // R5: most negative operand
      run_op(8'h80, 8'h80, 0, "R5 -128*-128");
      chk(prod_o == 16'h4000, "R5 +16384", int'(prod_o), 16384);
      run_op(8'h80, 8'h7F, 0, "R5 -128*127");
      run_op(8'h7F, 8'h80, 0, "R5 127*-128");
      run_op(8'h80, 8'h01, 0, "R5 -128*1");
      run_op(8'h01, 8'h80, 0, "R5 1*-128");

      // R8: pair patterns (00 only, 11 after one 10, alternating 01/10)
      run_op(8'h6D, 8'h00, 0, "R8 pairs 00");
      run_op(8'h6D, 8'hFF, 0, "R8 pairs 10/11");
      run_op(8'h93, 8'h55, 0, "R8 pairs 01/10");
      run_op(8'h93, 8'hAA, 0, "R8 pairs 10/01");

      // R6: start while busy and on the final step
      run_op(8'h25, 8'hE3, 1, "R6 busy start ignored");
      run_op(8'h80, 8'h80, 1, "R6 busy start ignored");

      // R9 and R2: start held high, operands switched while busy
      @(negedge clk);
      mcand_i = 8'h0B; mplier_i = 8'hF9; start_i = 1'b1;
      @(posedge clk);
      @(negedge clk);
      mcand_i = 8'hC4; mplier_i = 8'h37;          // captured on the next accept
      repeat (7) @(posedge clk);
      @(posedge clk);
      @(negedge clk);
      chk(done_o == 1'b1, "R9 first done", int'(done_o), 1);
      chk(prod_o == expmul(8'h0B, 8'hF9), "R2 R9 first product",
          int'($signed(prod_o)), int'($signed(expmul(8'h0B, 8'hF9))));
      @(posedge clk);                              // re-accept edge
      @(negedge clk);
      start_i = 1'b0;
      chk(done_o == 1'b0, "R9 gap", int'(done_o), 0);
      repeat (7) @(posedge clk);
      @(negedge clk);
      chk(done_o == 1'b0, "R9 second early", int'(done_o), 0);
      @(posedge clk);
      @(negedge clk);
      chk(done_o == 1'b1, "R9 second done", int'(done_o), 1);
      chk(prod_o == expmul(8'hC4, 8'h37), "R9 second product",
          int'($signed(prod_o)), int'($signed(expmul(8'hC4, 8'h37))));
      prev_exp = prod_o;
      @(posedge clk);
      @(negedge clk);

      // R4 R8: sweep every value against the edge set, both roles
      for (int i = 0; i < 256; i++) begin
         for (int k = 0; k < 18; k++) begin
            run_op(8'(i), corners[k], 0, "R4 R8 sweep mcand");
            run_op(corners[k], 8'(i), 0, "R4 R8 sweep mplier");
         end
      end

      if (!ended) begin
         ended = 1;
         $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

endmodule